// File: doc/BRIEF.md
# Signed Array Multiplier

This block multiplies two K-bit two's-complement operands and returns their full 2K-bit two's-complement product. The work is done by a regular grid of AND/NAND partial-product gates feeding rows of full-adder cells in carry-save form. A ripple-carry row at the bottom merges the sum and carry vectors into the result. The sign bits carry negative weight. That weight is absorbed inside the grid: every partial product that pairs exactly one sign bit with a non-sign bit is inverted, and constant ones are seeded into column K and column 2K-1. As a result, every adder cell sums only non-negative bits, and nothing outside the grid corrects the sign.

A parameter `STAGES` selects how many register ranks are inserted between adder rows. With `STAGES = 0` the block is purely combinational. With `STAGES > 0`, operand bits travel with the partial sums through the ranks. A valid flag advances beside the data, and a rank only loads when the flag entering it is set. The last product therefore stays on the output until the next valid result arrives. A new operand pair may be presented on every clock.

Top module: `mbw_array_mult`

## Requirements
- R1: `product` equals the signed product of `opA` and `opB`, as a 2K-bit two's-complement value, for every operand pair. With K=5, this covers all 1024 pairs.
- R2: Corner cases are exact for K=5:
  - (-16)·(-16) gives 0x100.
  - (-16)·15 gives 0x310.
  - (-1)·(-1) gives 0x001.
  - 0 times any value gives 0x000.
  - 15·15 gives 0x0E1.
- R3: With `STAGES > 0`, a pair accepted with `inValid` high at a rising edge appears on `product` exactly `STAGES` rising edges later. `outValid` is high in that cycle only.
- R4: With `STAGES = 0`, `product` settles in the same cycle as its operands, and `outValid` equals `inValid`.
- R5: With `STAGES > 0`, `outValid` is 0 and `product` is 0 after reset, until the first valid result emerges.
- R6: With `STAGES > 0`, `product` holds its last value in every cycle in which `outValid` is 0.
- R7: Pairs presented on consecutive cycles produce results on consecutive cycles, in the same order.
- R8: Operand values presented while `inValid` is 0 have no effect on `product` or `outValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operands on `opA`/`opB` are to be multiplied |
| opA | input | K | Multiplicand, two's complement |
| opB | input | K | Multiplier, two's complement |
| outValid | output | 1 | `product` holds a new result this cycle |
| product | output | 2K | Two's-complement product |

## Verification
The combinational instance is checked one time step after each operand change, with no clock edge in between. The pipelined instance's result is due exactly `STAGES` rising edges after the edge that accepts the pair. The bench drives operands on falling edges and samples on the falling edge `STAGES` cycles later. In streaming runs, the bench checks entry n−`STAGES` before driving entry n, so every comparison falls in the single cycle the result is due. The latency and hold scenarios also sample the cycles just before and after that due cycle. This confirms `outValid` is low there and that the product has not moved.

// File: rtl/mbw_pkg.sv
package mbw_pkg;
  // Upper bound on register ranks; sizes the strobe vector.
  localparam int MAX_STAGES = 16;

  // Per-rank load strobes from control to datapath.
  typedef struct packed {
    logic [MAX_STAGES-1:0] load;
  } mbwStrobes_t;
endpackage

// File: rtl/mbw_control.sv
module mbw_control
  import mbw_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output mbwStrobes_t strobes,
  output logic        outValid
);
  generate
    if (STAGES > 0) begin : gPiped
      logic [STAGES-1:0] validSh;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          validSh <= '0;
        end else begin
          validSh[0] <= inValid;
          for (int s = 1; s < STAGES; s++) validSh[s] <= validSh[s-1];
        end
      end

      // Rank s loads when the valid flag entering it is set.
      always_comb begin
        strobes.load = '0;
        strobes.load[0] = inValid;
        for (int s = 1; s < STAGES; s++) strobes.load[s] = validSh[s-1];
      end

      assign outValid = validSh[STAGES-1];
    end else begin : gComb
      assign strobes.load = '0;
      assign outValid = inValid;
    end
  endgenerate
endmodule

// File: rtl/mbw_datapath.sv
module mbw_datapath
  import mbw_pkg::*;
#(
  parameter int K      = 5,
  parameter int STAGES = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  mbwStrobes_t    strobes,
  input  logic [K-1:0]   opA,
  input  logic [K-1:0]   opB,
  output logic [2*K-1:0] product
);
  localparam int W = 2 * K;
  // Constant ones of the sign rewrite: column K and column 2K-1.
  localparam logic [W-1:0] SEED = (W'(1) << K) | (W'(1) << (W - 1));
  // First row followed by a register rank.
  localparam int FIRST_REG = K - STAGES;

  // State entering row r; index K feeds the ripple row.
  logic [W-1:0] sumIn   [K+1];
  logic [W-1:0] carryIn [K+1];
  logic [K-1:0] aIn     [K+1];
  logic [K-1:0] bIn     [K+1];

  assign sumIn[0]   = '0;
  assign carryIn[0] = '0;
  assign aIn[0]     = opA;
  assign bIn[0]     = opB;

  generate
    for (genvar r = 0; r < K; r++) begin : gRow
      logic [W-1:0] ppVec;
      logic [W-1:0] sumOut;
      logic [W-1:0] carryOut;

      // Partial products of multiplier bit r, placed at column r+j.
      // Mixed sign/non-sign pairs are inverted (NAND cells).
      always_comb begin
        ppVec = '0;
        for (int j = 0; j < K; j++) begin
          ppVec[r+j] = aIn[r][j] & bIn[r][r];
          if ((r == K - 1) != (j == K - 1)) ppVec[r+j] = ~ppVec[r+j];
        end
      end

      if (r == 0) begin : gTop
        assign sumOut   = ppVec;
        assign carryOut = SEED;
      end else begin : gAdd
        // One full adder per column; carries move one column left.
        logic [W-1:0] majVec;
        always_comb begin
          for (int c = 0; c < W; c++) begin
            sumOut[c] = sumIn[r][c] ^ carryIn[r][c] ^ ppVec[c];
            majVec[c] = (sumIn[r][c] & carryIn[r][c]) |
                        (sumIn[r][c] & ppVec[c]) |
                        (carryIn[r][c] & ppVec[c]);
          end
        end
        assign carryOut = {majVec[W-2:0], 1'b0};
      end

      if (r >= FIRST_REG) begin : gReg
        localparam int SIDX = r - FIRST_REG;
        logic [W-1:0] sumQ, carryQ;
        logic [K-1:0] aQ, bQ;

        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            sumQ   <= '0;
            carryQ <= '0;
            aQ     <= '0;
            bQ     <= '0;
          end else if (strobes.load[SIDX]) begin
            sumQ   <= sumOut;
            carryQ <= carryOut;
            aQ     <= aIn[r];
            bQ     <= bIn[r];
          end
        end

        assign sumIn[r+1]   = sumQ;
        assign carryIn[r+1] = carryQ;
        assign aIn[r+1]     = aQ;
        assign bIn[r+1]     = bQ;
      end else begin : gWire
        assign sumIn[r+1]   = sumOut;
        assign carryIn[r+1] = carryOut;
        assign aIn[r+1]     = aIn[r];
        assign bIn[r+1]     = bIn[r];
      end
    end
  endgenerate

  // Ripple row; carry out of the top column is dropped.
  always_comb begin
    logic rip;
    rip = 1'b0;
    for (int c = 0; c < W; c++) begin
      product[c] = sumIn[K][c] ^ carryIn[K][c] ^ rip;
      rip = (sumIn[K][c] & carryIn[K][c]) | (rip & (sumIn[K][c] ^ carryIn[K][c]));
    end
  end
endmodule

// File: rtl/mbw_array_mult.sv
module mbw_array_mult
  import mbw_pkg::*;
#(
  parameter int K      = 5,
  parameter int STAGES = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           inValid,
  input  logic [K-1:0]   opA,
  input  logic [K-1:0]   opB,
  output logic           outValid,
  output logic [2*K-1:0] product
);
  localparam int CW = $clog2(STAGES + 2) + 1;

  mbwStrobes_t strobes;

  mbw_control #(.STAGES(STAGES)) control_i (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .strobes(strobes), .outValid(outValid)
  );

  mbw_datapath #(.K(K), .STAGES(STAGES)) datapath_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .opA(opA), .opB(opB), .product(product)
  );

  // Bookkeeping for assertions only.
  logic [CW-1:0] inFlight;
  logic          sawResult;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFlight  <= '0;
      sawResult <= 1'b0;
    end else begin
      inFlight  <= inFlight + CW'(inValid) - CW'(outValid);
      if (outValid) sawResult <= 1'b1;
    end
  end

  // R3: never more pairs in flight than register ranks
  a_r3_inflight_bound: assert property (@(posedge clk) disable iff (!rstN)
    inFlight <= CW'(STAGES));

  generate
    if (STAGES > 0) begin : gPipeChk
      // R3: a result only emerges when something was accepted earlier
      a_r3_out_has_source: assert property (@(posedge clk) disable iff (!rstN)
        outValid |-> inFlight != '0);
      // R6: output frozen while no result is due
      a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
        !outValid |-> $stable(product));
      // R5: zero output until the first result
      a_r5_zero_until_first: assert property (@(posedge clk) disable iff (!rstN)
        (!sawResult && !outValid) |-> product == '0);
    end else begin : gCombChk
      // R1: combinational result matches the signed product
      a_r1_comb_product: assert property (@(posedge clk) disable iff (!rstN)
        inValid |-> $signed(product) == $signed(opA) * $signed(opB));
      // R2: most negative squared is the positive 2^(2K-2)
      a_r2_min_square: assert property (@(posedge clk) disable iff (!rstN)
        (opA == {1'b1, {(K-1){1'b0}}} && opB == {1'b1, {(K-1){1'b0}}})
          |-> product == (2*K)'(1) << (2*K - 2));
    end
  endgenerate
endmodule

// File: tb/mbw_array_mult_tb_top.sv
module mbw_array_mult_tb_top;
  localparam int K  = 5;
  localparam int PS = 2;
  localparam int W  = 2 * K;
  localparam int N  = 1 << (2 * K);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [K-1:0] opA = '0, opB = '0;
  logic outValid;
  logic [W-1:0] product;

  logic cValid = 1'b0;
  logic [K-1:0] cA = '0, cB = '0;
  logic cOutValid;
  logic [W-1:0] cProduct;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mbw_array_mult #(.K(K), .STAGES(PS)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .outValid(outValid), .product(product)
  );

  mbw_array_mult #(.K(K), .STAGES(0)) combI (
    .clk(clk), .rstN(rstN), .inValid(cValid), .opA(cA), .opB(cB),
    .outValid(cOutValid), .product(cProduct)
  );

  function automatic logic [W-1:0] refMul(logic [K-1:0] a, logic [K-1:0] b);
    int sa, sb;
    sa = a[K-1] ? int'(a) - (1 << K) : int'(a);
    sb = b[K-1] ? int'(b) - (1 << K) : int'(b);
    return W'(sa * sb);
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // R5: state after reset
  task automatic testReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R5 outValid", W'(outValid), '0);
    check("R5 product", product, '0);
  endtask

  // R1, R4: every pair through the combinational instance
  task automatic testCombAll();
    for (int n = 0; n < N; n++) begin
      cA = K'(n >> K); cB = K'(n); cValid = n[0];
      #1;
      check("R1 comb", cProduct, refMul(cA, cB));
      check("R4 comb valid", W'(cOutValid), W'(cValid));
    end
    cValid = 1'b0;
  endtask

  // R2: named corner values
  task automatic testCorners();
    logic [K-1:0] av [6] = '{5'h10, 5'h10, 5'h1f, 5'h00, 5'h00, 5'h0f};
    logic [K-1:0] bv [6] = '{5'h10, 5'h0f, 5'h1f, 5'h10, 5'h0b, 5'h0f};
    logic [W-1:0] ev [6] = '{10'h100, 10'h310, 10'h001, 10'h000, 10'h000, 10'h0e1};
    for (int i = 0; i < 6; i++) begin
      cA = av[i]; cB = bv[i];
      #1;
      check("R2 corner", cProduct, ev[i]);
    end
  endtask

  // R3: single pulse, exact latency
  task automatic testLatency();
    @(negedge clk);
    opA = 5'h13; opB = 5'h06; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0; opA = '0; opB = '0;
    for (int i = 1; i < PS; i++) begin
      check("R3 early", W'(outValid), '0);
      @(negedge clk);
    end
    check("R3 due valid", W'(outValid), 1);
    check("R3 due product", product, refMul(5'h13, 5'h06));
    @(negedge clk);
    check("R3 after", W'(outValid), '0);
  endtask

  // R6, R8: junk operands with inValid low leave the output frozen
  task automatic testHold();
    logic [W-1:0] held;
    held = product;
    for (int i = 0; i < PS + 4; i++) begin
      opA = K'(i * 7 + 3); opB = K'(i * 11 + 5); inValid = 1'b0;
      @(negedge clk);
      check("R8 no valid", W'(outValid), '0);
      check("R6 hold", product, held);
    end
  endtask

  // R1, R7: every pair back to back through the pipelined instance
  task automatic testStream();
    for (int t = 0; t < N + PS; t++) begin
      if (t >= PS) begin
        check("R7 valid", W'(outValid), 1);
        check("R1 stream", product, refMul(K'((t - PS) >> K), K'(t - PS)));
      end
      if (t < N) begin
        opA = K'(t >> K); opB = K'(t); inValid = 1'b1;
      end else begin
        inValid = 1'b0;
      end
      @(negedge clk);
    end
    check("R7 drained", W'(outValid), '0);
  endtask

  initial begin
    testReset();
    testCombAll();
    testCorners();
    testLatency();
    testHold();
    testStream();
    testHold();
    finish();
  end

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish();
  end
endmodule